// File: doc/BRIEF.md
# SPI Command Decoder with Sequencing Guard

This block sits behind the pins of an SPI slave and turns 20-bit command frames into one-cycle command strobes for the rest of the device. Each frame is shifted in most significant bit first while chip select is low. The first five bits are an opcode and the last fifteen are a parameter. The block resynchronises the serial pins to the system clock, counts the clock edges, and judges the frame when chip select returns high.

A frame that is decoded correctly is still executed only if two conditions hold. The command must be allowed to follow the last executed command, and the minimum quiet time set by that last command must have passed. A command that breaks either rule is dropped and latches a sticky violation flag. A valid power-up command stores an 8-bit clock divider and a 2-bit sample-rate code, and it clears the flag.

Top module: `spi_cmd_guard`

## Requirements
- R1: A frame of exactly 20 SCLK rising edges, first bit opcode bit 4, is split into opcode (first 5 bits) and parameter (last 15 bits); when executed, `cmd_stb` pulses for one cycle with `cmd_op` and `cmd_arg` holding those fields.
- R2: A frame with any edge count other than 20 pulses `frame_err`. It executes nothing, leaves `violation` unchanged, and does not alter the follow-on state.
- R3: An opcode outside the set {00000 NOP, 00001 SID, 00010 SET_FWD, 00011 FWD, 00100 PWRUP, 00110 STOP, 00111 STOP_PWDN} is rejected.
- R4: After an executed SET_FWD or FWD, only SET_FWD, FWD, STOP or STOP_PWDN execute; any other command is rejected.
- R5: After an executed STOP_PWDN, only PWRUP executes.
- R6: A command is rejected if it is judged fewer than SHORT_GAP cycles after an executed NOP or SID, or fewer than LONG_GAP cycles after an executed PWRUP. The other commands impose no wait.
- R7: An executed PWRUP loads `cfg_div` from parameter bits 9..2 and `cfg_rate` from bits 1..0, and it clears `violation`. These outputs change at no other time.
- R8: A PWRUP with any of parameter bits 14..10 set is rejected, and `cfg_div` and `cfg_rate` keep their values.
- R9: Every rejection pulses `cmd_rej` and sets `violation`. The flag stays set through later executed commands other than PWRUP.
- R10: Each frame produces exactly one of `cmd_stb`, `cmd_rej` or `frame_err`, on the third system-clock edge after chip select rises.
- R11: After reset, all outputs are zero and the first command may be any known opcode with no wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock, data taken on its rising edge |
| spi_cs_n | input | 1 | Active-low chip select framing a command |
| spi_sdi | input | 1 | Serial data in, MSB first |
| cmd_stb | output | 1 | One-cycle pulse for an executed command |
| cmd_op | output | 5 | Opcode of the last executed command |
| cmd_arg | output | 15 | Parameter of the last executed command |
| cmd_rej | output | 1 | One-cycle pulse for a rejected command |
| frame_err | output | 1 | One-cycle pulse for a frame of wrong length |
| violation | output | 1 | Sticky flag for a rejected command |
| cfg_div | output | 8 | Stored external-clock divider ratio |
| cfg_rate | output | 2 | Stored sample-rate code |

## Verification
Chip select passes through two synchroniser stages and then the judging register. Each frame's outcome is therefore due on the third clock edge after the bench raises chip select. The driver pushes the expected outcome before that rise and checks that the outcome is still pending after two edges and has been consumed after four. This pins every outcome to exactly that third edge. The configuration outputs and the violation flag are read only after that window closes. Timing rules are exercised with quiet gaps chosen well below or well above the configured limits.

// File: rtl/spi_cmd_guard.sv
module spi_cmd_guard #(
  parameter int SHORT_GAP = 5,
  parameter int LONG_GAP  = 5000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sclk,
  input  logic        spi_cs_n,
  input  logic        spi_sdi,
  output logic        cmd_stb,
  output logic [4:0]  cmd_op,
  output logic [14:0] cmd_arg,
  output logic        cmd_rej,
  output logic        frame_err,
  output logic        violation,
  output logic [7:0]  cfg_div,
  output logic [1:0]  cfg_rate
);
  localparam int FRAME = 20;
  localparam int W = $clog2(LONG_GAP + 1);
  localparam logic [W-1:0] SHORT_V = W'(SHORT_GAP);
  localparam logic [W-1:0] LONG_V  = W'(LONG_GAP);

  localparam logic [4:0] OP_NOP = 5'b00000, OP_SID = 5'b00001, OP_SFWD = 5'b00010,
                         OP_FWD = 5'b00011, OP_PWR = 5'b00100, OP_STOP = 5'b00110,
                         OP_PDN = 5'b00111;

  typedef enum logic [1:0] {FOL_ANY, FOL_FWD, FOL_PWR} fol_t;

  logic sclk_m, sclk_s, sclk_q, cs_m, cs_s, cs_q, sdi_m, sdi_s;
  logic [FRAME-1:0] sh;
  logic [4:0] cnt;
  logic [W-1:0] since, need;
  fol_t fol;

  wire sclk_rise = sclk_s & ~sclk_q;
  wire cs_rise   = cs_s & ~cs_q;
  wire cs_fall   = ~cs_s & cs_q;
  wire [4:0]  op  = sh[19:15];
  wire [14:0] arg = sh[14:0];

  logic known, allowed;
  always_comb begin
    unique case (op)
      OP_NOP, OP_SID, OP_SFWD, OP_FWD, OP_PWR, OP_STOP, OP_PDN: known = 1'b1;
      default: known = 1'b0;
    endcase
    unique case (fol)
      FOL_FWD: allowed = (op == OP_SFWD) || (op == OP_FWD) || (op == OP_STOP) || (op == OP_PDN);
      FOL_PWR: allowed = (op == OP_PWR);
      default: allowed = 1'b1;
    endcase
  end

  wire pwr_bad = (op == OP_PWR) && (arg[14:10] != 5'd0);
  wire accept  = known && allowed && (since >= need) && !pwr_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {sclk_m, sclk_s, sclk_q, sdi_m, sdi_s} <= '0;
      {cs_m, cs_s, cs_q} <= 3'b111;
      sh <= '0;
      cnt <= '0;
      since <= LONG_V;
      need <= '0;
      fol <= FOL_ANY;
      {cmd_stb, cmd_rej, frame_err, violation} <= '0;
      cmd_op <= '0;
      cmd_arg <= '0;
      cfg_div <= '0;
      cfg_rate <= '0;
    end else begin
      sclk_m <= spi_sclk; sclk_s <= sclk_m; sclk_q <= sclk_s;
      cs_m <= spi_cs_n;   cs_s <= cs_m;     cs_q <= cs_s;
      sdi_m <= spi_sdi;   sdi_s <= sdi_m;
      cmd_stb <= 1'b0;
      cmd_rej <= 1'b0;
      frame_err <= 1'b0;
      if (since != LONG_V) since <= since + 1'b1;
      if (cs_fall) cnt <= '0;
      else if (sclk_rise && !cs_s) begin
        sh <= {sh[FRAME-2:0], sdi_s};
        if (cnt != 5'd31) cnt <= cnt + 1'b1;
      end
      if (cs_rise) begin
        if (cnt != 5'(FRAME)) frame_err <= 1'b1;
        else if (!accept) begin
          cmd_rej <= 1'b1;
          violation <= 1'b1;
        end else begin
          cmd_stb <= 1'b1;
          cmd_op <= op;
          cmd_arg <= arg;
          since <= W'(1);
          need <= '0;
          fol <= FOL_ANY;
          unique case (op)
            OP_PWR: begin
              need <= LONG_V;
              cfg_div <= arg[9:2];
              cfg_rate <= arg[1:0];
              violation <= 1'b0;
            end
            OP_NOP, OP_SID: need <= SHORT_V;
            OP_SFWD, OP_FWD: fol <= FOL_FWD;
            OP_PDN: fol <= FOL_PWR;
            default: ;
          endcase
        end
      end
    end
  end

  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_stb, cmd_rej, frame_err}));
  a_r9_rej_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rej |-> violation);
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> violation || (cmd_stb && cmd_op == OP_PWR));
  a_r7_cfg_only_on_pwrup: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_stb && cmd_op == OP_PWR) |-> ($stable(cfg_div) && $stable(cfg_rate)));
  a_r8_pwrup_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && cmd_op == OP_PWR) |-> (cmd_arg[14:10] == 5'd0));
  a_r2_ferr_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $stable(violation));
endmodule

// File: tb/test_spi_cmd_guard.sv
module test_spi_cmd_guard;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic cmd_stb, cmd_rej, frame_err, violation;
  logic [4:0] cmd_op;
  logic [14:0] cmd_arg;
  logic [7:0] cfg_div;
  logic [1:0] cfg_rate;
  int total = 0, bad = 0;
  logic [21:0] q[$];
  string tq[$];

  always #4 clk = ~clk;

  spi_cmd_guard #(.SHORT_GAP(400), .LONG_GAP(2000)) i_spi_cmd_guard (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_sdi(sdi),
    .cmd_stb(cmd_stb), .cmd_op(cmd_op), .cmd_arg(cmd_arg), .cmd_rej(cmd_rej),
    .frame_err(frame_err), .violation(violation), .cfg_div(cfg_div), .cfg_rate(cfg_rate));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // kind: 0 executed, 1 rejected, 2 framing error
  task automatic send(int nb, logic [19:0] fr, int kind, string tag);
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      sdi = (i < 20) ? fr[19-i] : 1'b0;
      repeat (8) @(negedge clk);
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    q.push_back({2'(kind), fr});
    tq.push_back(tag);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    #1 check({tag, " R10 not before third edge"}, q.size(), 1);
    repeat (2) @(negedge clk);
    #1 check({tag, " R10 due on third edge"}, q.size(), 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && (cmd_stb || cmd_rej || frame_err)) begin
      logic [1:0] k;
      k = cmd_stb ? 2'd0 : (cmd_rej ? 2'd1 : 2'd2);
      if (q.size() == 0) begin
        total++; bad++;
        $display("FAIL R10 unexpected outcome actual=%0d expected=none", k);
      end else begin
        logic [21:0] e;
        string t;
        e = q.pop_front();
        t = tq.pop_front();
        check({t, " kind"}, k, e[21:20]);
        if (e[21:20] == 2'd0) check({t, " op/arg"}, {cmd_op, cmd_arg}, e[19:0]);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 reset outputs", {cmd_stb, cmd_rej, frame_err, violation, cmd_op, cmd_arg, cfg_div, cfg_rate}, 0);
    send(20, {5'b00100, 5'd0, 8'hA5, 2'b10}, 0, "R11 first PWRUP");
    check("R7 div", cfg_div, 8'hA5);
    check("R7 rate", cfg_rate, 2'b10);
    repeat (2100) @(negedge clk);
    send(20, {5'b00000, 15'h7FFF}, 0, "R1 NOP");
    send(20, {5'b00001, 15'h0}, 1, "R6 SID too soon after NOP");
    check("R9 flag set", violation, 1);
    repeat (500) @(negedge clk);
    send(20, {5'b00001, 15'h0123}, 0, "R6 SID after gap");
    check("R9 flag held", violation, 1);
    repeat (500) @(negedge clk);
    send(20, {5'b00010, 15'h1234}, 0, "R1 SET_FWD");
    send(19, {5'b00110, 15'h0}, 2, "R2 short frame");
    send(21, {5'b00110, 15'h0}, 2, "R2 long frame");
    check("R2 flag unchanged", violation, 1);
    send(20, {5'b00000, 15'h0}, 1, "R4 NOP after SET_FWD");
    send(20, {5'b00011, 15'h0}, 0, "R4 FWD after SET_FWD");
    send(20, {5'b00110, 15'h0}, 0, "R4 STOP after FWD");
    send(20, {5'b00111, 15'h0}, 0, "R5 STOP_PWDN");
    send(20, {5'b00110, 15'h0}, 1, "R5 STOP after STOP_PWDN");
    send(20, {5'b00100, 5'b10000, 8'h3C, 2'b01}, 1, "R8 PWRUP high bits");
    check("R8 div kept", cfg_div, 8'hA5);
    check("R8 rate kept", cfg_rate, 2'b10);
    send(20, {5'b00100, 5'd0, 8'h3C, 2'b01}, 0, "R5 PWRUP after STOP_PWDN");
    check("R7 div reload", cfg_div, 8'h3C);
    check("R7 rate reload", cfg_rate, 2'b01);
    check("R7 flag cleared", violation, 0);
    send(20, {5'b00110, 15'h0}, 1, "R6 STOP too soon after PWRUP");
    repeat (2100) @(negedge clk);
    send(20, {5'b01010, 15'h0}, 1, "R3 unknown opcode");
    send(20, {5'b00110, 15'h0}, 0, "R3 STOP after unknown");
    check("R9 flag after STOP", violation, 1);
    check("R10 queue drained", q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule